// File: doc/BRIEF.md
# Tagged DAC Conversion Data Queue

This block is the write-side front end of a multi-channel DAC controller. Software writes a 32-bit conversion-data word. The block turns each write into one or two 16-bit queue entries and stores them in a small FIFO. Each entry carries a 12-bit sample in bits [11:0] and a 2-bit channel tag in bits [13:12]. Bits [15:14] of each half are discarded. In half-word mode one write stores bits [15:0] of the word. In paired mode one write stores bits [15:0] first and then bits [31:16].

On the converter side the head entry is offered on a valid/ready stream: `cv_valid` is high whenever the queue holds an entry. The sample and channel stay stable until the consumer raises `cv_ready`, so the consumer applies back-pressure by keeping `cv_ready` low. The channel comes from the entry's tag when tagging is enabled and from `cfg_user_chan` when it is not. The choice uses the configuration present when the entry is at the head.

The write side is not a handshake. `wr_rdy` is a plain status flag that software must test before it writes. A write made while the flag is low is discarded and sets a sticky overrun flag, which only reset clears.

Top module: `dac_conv_queue`

## Requirements
- R1: After reset the queue is empty: `cv_valid` is 0, `ovr_err` is 0, and `wr_rdy` is 1 whenever `conv_en` is 1.
- R2: With `cfg_word_mode`=0, an accepted write stores exactly one entry, taken from `wr_data[15:0]`.
- R3: With `cfg_word_mode`=1, an accepted write stores two entries: `wr_data[15:0]` first, then `wr_data[31:16]`.
- R4: The queue holds four entries. With `cfg_word_mode`=0, `wr_rdy` is 0 exactly when all four entries are occupied, provided `conv_en` is 1.
- R5: With `cfg_word_mode`=1, `wr_rdy` is 1 only when at least two entries are free, so a paired write never splits.
- R6: `wr_rdy` is 0 whenever `conv_en` is 0.
- R7: A write while `wr_rdy` is 0 leaves the queue contents unchanged and sets `ovr_err`. `ovr_err` then stays 1 until reset.
- R8: `cv_sample` equals bits [11:0] of the head entry. `cv_chan` equals bits [13:12] of the head entry when `cfg_tag_en`=1, and equals `cfg_user_chan` when `cfg_tag_en`=0.
- R9: Exactly one entry is removed on each cycle where `cv_valid` and `cv_ready` are both 1. While `cv_valid`=1 and `cv_ready`=0, the head sample holds stable.
- R10: A push and a pop in the same cycle both take effect. Write admission is judged on the occupancy before the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word_mode | input | 1 | 1: one write stores two entries |
| cfg_tag_en | input | 1 | 1: channel comes from each entry's tag |
| cfg_user_chan | input | 2 | Channel used when tagging is off |
| conv_en | input | 1 | Converter side can take requests |
| wr_valid | input | 1 | Write strobe for the conversion-data word |
| wr_data | input | 32 | Conversion-data word |
| wr_rdy | output | 1 | Writes are accepted this cycle |
| ovr_err | output | 1 | Sticky: a write was dropped |
| cv_valid | output | 1 | Head entry available |
| cv_ready | input | 1 | Converter takes the head entry |
| cv_sample | output | 12 | Head sample value |
| cv_chan | output | 2 | Channel for the head sample |

## Verification
Some properties are checked on every cycle by assertions in the RTL:
- The occupancy never exceeds four.
- `wr_rdy` in paired mode never coexists with fewer than two free entries.
- A dropped write never changes the occupancy.
- `ovr_err` never falls outside reset.
- A stalled head sample never changes.

Other behaviour depends on data and order, so only the bench's scenarios against its queue model show it:
- The half order in paired mode.
- Tag-versus-user channel routing, including reconfiguration while entries wait.
- Simultaneous push and pop at the full boundary.
- The drop of writes while `conv_en` is low.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int SAMPLE_W = 12;
  localparam int CHAN_W   = 2;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 2 * HALF_W;

  typedef struct packed {
    logic [CHAN_W-1:0]   tag;
    logic [SAMPLE_W-1:0] sample;
  } dcq_entry_t;

  localparam int ENTRY_W = $bits(dcq_entry_t);
endpackage

// File: rtl/dcq_unpack.sv
module dcq_unpack
  import dcq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dcq_entry_t        lo_entry,
  output dcq_entry_t        hi_entry
);
  localparam int TAG_LSB = SAMPLE_W;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] half;
    dcq_entry_t        ent;
    assign half       = word[h*HALF_W +: HALF_W];
    assign ent.sample = half[SAMPLE_W-1:0];
    assign ent.tag    = half[TAG_LSB +: CHAN_W];
    if (h == 0) begin : g_lo
      assign lo_entry = ent;
    end else begin : g_hi
      assign hi_entry = ent;
    end
  end
endmodule

// File: rtl/dcq_admit.sv
module dcq_admit #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          word_mode,
  input  logic          conv_en,
  input  logic          wr_valid,
  output logic          wr_rdy,
  output logic          accept,
  output logic          ovr_err
);
  logic [CW-1:0] free_slots;
  logic          room;

  assign free_slots = CW'(DEPTH) - count;
  assign room       = word_mode ? (free_slots >= CW'(2)) : (free_slots != '0);
  assign wr_rdy     = conv_en && room;
  assign accept     = wr_valid && wr_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovr_err <= 1'b0;
    else if (wr_valid && !wr_rdy) ovr_err <= 1'b1;
  end

  // R5: a paired write is admitted only with two free entries
  a_r5_pair_room: assert property (@(posedge clk) disable iff (!rst_n)
    (word_mode && wr_rdy) |-> (count <= CW'(DEPTH - 2)));
  // R7: the overrun flag is sticky
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |=> ovr_err);
  // R6: a disabled converter blocks admission
  a_r6_conv_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |-> !accept);
endmodule

// File: rtl/dcq_store.sv
module dcq_store
  import dcq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_pair,
  input  dcq_entry_t    in_lo,
  input  dcq_entry_t    in_hi,
  input  logic          pop,
  output dcq_entry_t    head,
  output logic [CW-1:0] count
);
  dcq_entry_t    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [1:0]    n_in;
  logic          n_out;

  assign n_in  = push ? (push_pair ? 2'd2 : 2'd1) : 2'd0;
  assign n_out = pop && (count != '0);
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wp] <= in_lo;
      if (push_pair) mem[wp + AW'(1)] <= in_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + AW'(n_in);
      rp    <= rp + AW'(n_out);
      count <= count + CW'(n_in) - CW'(n_out);
    end
  end

  // R4: occupancy never exceeds the depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R9: a pop with no push lowers the occupancy by one
  a_r9_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count != '0) |=> (count == $past(count) - CW'(1)));
  // R9: a stalled non-empty head keeps its contents
  a_r9_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && count != '0) |=> $stable(head));
endmodule

// File: rtl/dcq_route.sv
module dcq_route
  import dcq_pkg::*;
(
  input  dcq_entry_t          head,
  input  logic                tag_en,
  input  logic [CHAN_W-1:0]   user_chan,
  output logic [SAMPLE_W-1:0] sample,
  output logic [CHAN_W-1:0]   chan
);
  always_comb begin
    sample = head.sample;
    chan   = tag_en ? head.tag : user_chan;
  end
endmodule

// File: rtl/dac_conv_queue.sv
module dac_conv_queue
  import dcq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_word_mode,
  input  logic                cfg_tag_en,
  input  logic [CHAN_W-1:0]   cfg_user_chan,
  input  logic                conv_en,
  input  logic                wr_valid,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                wr_rdy,
  output logic                ovr_err,
  output logic                cv_valid,
  input  logic                cv_ready,
  output logic [SAMPLE_W-1:0] cv_sample,
  output logic [CHAN_W-1:0]   cv_chan
);
  localparam int CW = $clog2(DEPTH + 1);

  dcq_entry_t    e_lo, e_hi, head;
  logic [CW-1:0] count;
  logic          accept, pop;

  dcq_unpack u_unpack (
    .word     (wr_data),
    .lo_entry (e_lo),
    .hi_entry (e_hi)
  );

  dcq_admit #(.DEPTH(DEPTH)) u_admit (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .word_mode (cfg_word_mode),
    .conv_en   (conv_en),
    .wr_valid  (wr_valid),
    .wr_rdy    (wr_rdy),
    .accept    (accept),
    .ovr_err   (ovr_err)
  );

  assign cv_valid = (count != '0);
  assign pop      = cv_valid && cv_ready;

  dcq_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_pair (cfg_word_mode),
    .in_lo     (e_lo),
    .in_hi     (e_hi),
    .pop       (pop),
    .head      (head),
    .count     (count)
  );

  dcq_route u_route (
    .head      (head),
    .tag_en    (cfg_tag_en),
    .user_chan (cfg_user_chan),
    .sample    (cv_sample),
    .chan      (cv_chan)
  );

  // R7: a dropped write leaves the occupancy alone
  a_r7_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_rdy && !pop) |=> (count == $past(count)));
  // R9: stalled output sample holds
  a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_valid && !cv_ready) |=> (cv_valid && $stable(cv_sample)));
endmodule

// File: tb/dac_conv_queue_tb.sv
module dac_conv_queue_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_word_mode = 0, cfg_tag_en = 0, conv_en = 1;
  logic [1:0]  cfg_user_chan = 0;
  logic        wr_valid = 0, cv_ready = 0;
  logic [31:0] wr_data = 0;
  logic        wr_rdy, ovr_err, cv_valid;
  logic [11:0] cv_sample;
  logic [1:0]  cv_chan;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [15:0] mq[$];
  bit m_ovr = 0;

  always #10 clk = ~clk;

  dac_conv_queue u_dut (.*);

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // One clock: inputs already set at the negedge; compare, advance the model.
  task automatic step();
    bit e_rdy, pop;
    int e_chan;
    #1;
    e_rdy = conv_en && (cfg_word_mode ? (4 - mq.size() >= 2) : (mq.size() < 4));
    chk(wr_rdy == e_rdy, "wr_rdy", wr_rdy, e_rdy);
    chk(cv_valid == (mq.size() > 0), "cv_valid", cv_valid, mq.size() > 0);
    chk(ovr_err == m_ovr, "ovr_err", ovr_err, m_ovr);
    if (mq.size() > 0) begin
      e_chan = cfg_tag_en ? int'(mq[0][13:12]) : int'(cfg_user_chan);
      chk(cv_sample == mq[0][11:0], "cv_sample", cv_sample, mq[0][11:0]);
      chk(cv_chan == e_chan[1:0], "cv_chan", cv_chan, e_chan);
    end
    pop = (mq.size() > 0) && cv_ready;
    if (pop) void'(mq.pop_front());
    if (wr_valid) begin
      if (e_rdy) begin
        mq.push_back(wr_data[15:0]);
        if (cfg_word_mode) mq.push_back(wr_data[31:16]);
      end else m_ovr = 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d, bit rdy_out);
    wr_valid = 1; wr_data = d; cv_ready = rdy_out;
    step();
    wr_valid = 0; cv_ready = 0;
  endtask

  task automatic idle(int n, bit rdy_out);
    for (int i = 0; i < n; i++) begin
      cv_ready = rdy_out;
      step();
    end
    cv_ready = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    mq.delete();
    m_ovr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    cur_req = "R1";
    idle(2, 0);

    // R2/R4: half-word fill with junk in upper bits, user channel
    cur_req = "R2"; cfg_user_chan = 2;
    wr(32'hFFFF_C123, 0);
    wr(32'h0000_3456, 0);
    cur_req = "R4";
    wr(32'h1234_8789, 0);
    wr(32'h5555_0ABC, 0);
    idle(1, 0);
    // R7: dropped write when full, ovr sticky
    cur_req = "R7";
    wr(32'h0000_0FFF, 0);
    idle(2, 0);
    // R9: drain with back-pressure gaps
    cur_req = "R9";
    idle(1, 1); idle(1, 0); idle(3, 1);

    // R8: tags, reconfiguration while entries wait
    cur_req = "R8"; cfg_tag_en = 1;
    wr(32'h0000_1111, 0);
    wr(32'h0000_2222, 0);
    wr(32'h0000_3333, 0);
    idle(1, 1);
    cfg_tag_en = 0; cfg_user_chan = 1;
    idle(1, 1);
    cfg_tag_en = 1;
    idle(2, 1);

    // R3/R5: paired mode
    cur_req = "R3"; cfg_word_mode = 1; cfg_tag_en = 1;
    wr(32'h2ABC_1DEF, 0);
    idle(1, 0);
    cur_req = "R5";
    cfg_word_mode = 0; wr(32'h0000_0777, 0);
    cfg_word_mode = 1; idle(1, 0);
    wr(32'h3999_0888, 0);
    idle(1, 1);
    wr(32'h1222_2333, 0);
    idle(5, 1);

    // R6: converter disabled
    cur_req = "R6"; cfg_word_mode = 0; conv_en = 0;
    wr(32'h0000_0444, 0);
    idle(1, 0);
    conv_en = 1;

    // R10: streaming push and pop at the full boundary
    cur_req = "R10";
    for (int i = 0; i < 4; i++) wr(32'h100 + i, 0);
    for (int i = 0; i < 6; i++) wr(32'h200 + i * 3, 1);
    idle(5, 1);

    // R1: reset clears queue and sticky flag
    cur_req = "R1";
    wr(32'h0000_0001, 0);
    do_reset();
    idle(2, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule